// File: doc/BRIEF.md
# Digit-Serial Binary-Field Arithmetic Unit

This block does arithmetic in GF(2^n) using a polynomial basis, with a fixed reduction polynomial f chosen at build time. It keeps three working registers: an operand register `a`, an operand shift register `b` and an accumulator `c`. Operands come in one word per cycle through a shared load port. An operation code selects one of three functions. Addition and squaring each take a single compute cycle. Multiplication consumes `D` bits of `b` per cycle, starting at the most significant digit, using a shift-and-reduce (Horner-style) recurrence.

An outer controller loads `a` and `b`, pulses `start` with an operation code, and waits for the one-cycle `done` pulse. It then takes the product or sum from `result`, which shows the accumulator until the next operation starts. The field width `n`, digit width `D` and the low coefficients of `f` are parameters. The number of multiply cycles is ceil(n/D). With `D = 1` the multiplier becomes plain bit-serial shift-and-add.

Top module: `gf2_digit_alu`

## Requirements
- R1: A cycle with `loadEn` high writes `loadData` into `a` when `loadSel` is 0 and into `b` when `loadSel` is 1. The write is ignored while `busy` is high, and also in any cycle where `start` is high.
- R2: Opcode 2'b00 (and the alias 2'b11) sets the accumulator to `a XOR b`. `done` is high in the cycle after the clock edge that samples `start`, and `busy` stays low.
- R3: Opcode 2'b01 sets the accumulator to a² mod f, with `done` timed as in R2.
- R4: Opcode 2'b10 sets the accumulator to a·b mod f. `done` is high in the cycle after the ceil(n/D)-th clock edge, counting the edge that samples `start` as the first. `busy` is high from the second of those edges until the last one.
- R5: With `D = 1` the multiply takes n cycles and yields the same product as any other digit width.
- R6: `done` is high for exactly one cycle per operation, never while `busy` is high. `result` holds its value from then until the next accepted `start`.
- R7: A `start` that arrives while `busy` is high is ignored. The running multiply finishes with its timing and product unchanged.
- R8: After reset, `result`, `done` and `busy` are 0, and `a` and `b` hold 0.
- R9: Multiplication shifts `b` out completely and leaves it 0. `a` keeps its value through every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write `loadData` into an operand register |
| loadSel | input | 1 | Target of the write: 0 = `a`, 1 = `b` |
| loadData | input | FIELD_W | Operand word |
| opSel | input | 2 | Operation code: 00 add, 01 square, 10 multiply, 11 add |
| start | input | 1 | Begin the selected operation (sampled while idle) |
| busy | output | 1 | Multiply iterations still pending |
| done | output | 1 | One-cycle pulse when the accumulator holds the result |
| result | output | FIELD_W | Accumulator contents |

## Verification
Two pairs of functions can collide. An operand load can arrive in the same cycle as `start`, and a new `start` or load can arrive while a multiply is in progress. The bench provokes both cases. It asserts `start` and a load of `a` together while the unit is idle. It also injects a stray `start` and a stray load into the second cycle of a multiply. Each collision is judged through the port: the result of the interrupted or concurrent operation is compared with the value computed from the old operands. A follow-up addition then shows whether `a` was overwritten. Three instances with digit widths 1, 2 and 3 run the same stimulus, so each collision meets a different number of remaining iterations.

// File: rtl/gf2_alu_pkg.sv
package gf2_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SQR     = 2'b01,
    OP_MUL     = 2'b10,
    OP_ADD_ALT = 2'b11
  } aluOp_e;

  // Strobes from control to datapath, valid for one clock cycle.
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic doAdd;
    logic doSqr;
    logic mulStep;
    logic mulFirst;
    logic mulLast;
  } aluStrobe_t;

endpackage

// File: rtl/gf2_alu_ctrl.sv
module gf2_alu_ctrl
  import gf2_alu_pkg::*;
#(
  parameter int NUM_DIGITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadEn,
  input  logic       loadSel,
  input  logic [1:0] opSel,
  input  logic       start,
  output aluStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(NUM_DIGITS + 1);

  typedef enum logic {ST_IDLE, ST_MUL} ctrlState_e;

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] stepCnt, stepCntNext;
  logic doneNext;
  aluOp_e opCode;

  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    stepCntNext = stepCnt;
    doneNext    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          unique case (opCode)
            OP_SQR: begin
              strobe.doSqr = 1'b1;
              doneNext     = 1'b1;
            end
            OP_MUL: begin
              strobe.mulStep  = 1'b1;
              strobe.mulFirst = 1'b1;
              strobe.mulLast  = (NUM_DIGITS == 1);
              if (NUM_DIGITS == 1) begin
                doneNext = 1'b1;
              end else begin
                stateNext   = ST_MUL;
                stepCntNext = CNT_W'(1);
              end
            end
            default: begin
              strobe.doAdd = 1'b1;
              doneNext     = 1'b1;
            end
          endcase
        end else if (loadEn) begin
          strobe.loadA = ~loadSel;
          strobe.loadB = loadSel;
        end
      end
      ST_MUL: begin
        strobe.mulStep = 1'b1;
        strobe.mulLast = (stepCnt == CNT_W'(NUM_DIGITS - 1));
        stepCntNext    = stepCnt + CNT_W'(1);
        if (strobe.mulLast) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
      done    <= doneNext;
    end
  end

  assign busy = (state == ST_MUL);

endmodule

// File: rtl/gf2_alu_datapath.sv
module gf2_alu_datapath
  import gf2_alu_pkg::*;
#(
  parameter int                 FIELD_W = 13,
  parameter int                 DIGIT_W = 3,
  parameter logic [FIELD_W-1:0] POLY    = 13'h001B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  aluStrobe_t         strobe,
  input  logic [FIELD_W-1:0] loadData,
  output logic [FIELD_W-1:0] accOut
);

  localparam int NUM_DIGITS = (FIELD_W + DIGIT_W - 1) / DIGIT_W;
  localparam int BREG_W     = NUM_DIGITS * DIGIT_W;
  localparam int WIDE_W     = 2 * FIELD_W;
  localparam logic [FIELD_W:0] FULL_POLY = {1'b1, POLY};

  logic [FIELD_W-1:0] aReg, cReg;
  logic [BREG_W-1:0]  bReg;
  logic [DIGIT_W-1:0] bTop;
  logic [WIDE_W-1:0]  spread, digitProd;
  logic [FIELD_W-1:0] sqrRes, accIn, mulSum, mulShift;

  // Fold every term of degree >= FIELD_W back below FIELD_W, from the top down.
  function automatic logic [FIELD_W-1:0] reduceWide(input logic [WIDE_W-1:0] v);
    logic [WIDE_W-1:0] t;
    t = v;
    for (int i = WIDE_W - 1; i >= FIELD_W; i--) begin
      if (t[i]) t = t ^ (WIDE_W'(FULL_POLY) << (i - FIELD_W));
    end
    return t[FIELD_W-1:0];
  endfunction

  // Squaring: coefficient i moves to degree 2i, then reduce.
  always_comb begin
    spread = '0;
    for (int i = 0; i < FIELD_W; i++) spread[2*i] = aReg[i];
    sqrRes = reduceWide(spread);
  end

  // Multiply step: top digit of b times a, added into the accumulator.
  assign bTop  = bReg[BREG_W-1 -: DIGIT_W];
  assign accIn = strobe.mulFirst ? '0 : cReg;

  always_comb begin
    digitProd = '0;
    for (int j = 0; j < DIGIT_W; j++) begin
      if (bTop[j]) digitProd = digitProd ^ (WIDE_W'(aReg) << j);
    end
    mulSum   = accIn ^ reduceWide(digitProd);
    mulShift = reduceWide(WIDE_W'(mulSum) << DIGIT_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg <= '0;
      bReg <= '0;
      cReg <= '0;
    end else begin
      if (strobe.loadA) aReg <= loadData;
      if (strobe.loadB) bReg <= BREG_W'(loadData);
      if (strobe.doAdd) cReg <= aReg ^ bReg[FIELD_W-1:0];
      if (strobe.doSqr) cReg <= sqrRes;
      if (strobe.mulStep) begin
        cReg <= strobe.mulLast ? mulSum : mulShift;
        bReg <= bReg << DIGIT_W;
      end
    end
  end

  assign accOut = cReg;

endmodule

// File: rtl/gf2_digit_alu.sv
module gf2_digit_alu
  import gf2_alu_pkg::*;
#(
  parameter int                 FIELD_W = 13,
  parameter int                 DIGIT_W = 3,
  parameter logic [FIELD_W-1:0] POLY    = 13'h001B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [FIELD_W-1:0] loadData,
  input  logic [1:0]         opSel,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [FIELD_W-1:0] result
);

  localparam int NUM_DIGITS = (FIELD_W + DIGIT_W - 1) / DIGIT_W;

  aluStrobe_t strobe;

  gf2_alu_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .loadEn  (loadEn),
    .loadSel (loadSel),
    .opSel   (opSel),
    .start   (start),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  gf2_alu_datapath #(.FIELD_W(FIELD_W), .DIGIT_W(DIGIT_W), .POLY(POLY)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .loadData (loadData),
    .accOut   (result)
  );

endmodule

// File: rtl/gf2_alu_checker.sv
module gf2_alu_checker #(
  parameter int FIELD_W = 13,
  parameter int DIGIT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               loadEn,
  input logic               loadSel,
  input logic [FIELD_W-1:0] loadData,
  input logic [1:0]         opSel,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [FIELD_W-1:0] result
);

  localparam int NUM_DIGITS = (FIELD_W + DIGIT_W - 1) / DIGIT_W;

  logic [FIELD_W-1:0] shadowA, shadowB;
  logic accept;

  assign accept = start && !busy;

  // Operand copies rebuilt from port traffic only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowA <= '0;
      shadowB <= '0;
    end else if (accept && opSel == 2'b10) begin
      shadowB <= '0;
    end else if (loadEn && !busy && !start) begin
      if (loadSel) shadowB <= loadData;
      else         shadowA <= loadData;
    end
  end

  AST_ADD_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opSel[0] == opSel[1]) |=> result == $past(shadowA ^ shadowB)); // R2

  AST_QUICK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opSel != 2'b10) |=> (done && !busy)); // R3

  AST_MUL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opSel == 2'b10 && NUM_DIGITS > 1) |=> (busy && !done)); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R6

  AST_BUSY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R7

endmodule

bind gf2_digit_alu gf2_alu_checker #(.FIELD_W(FIELD_W), .DIGIT_W(DIGIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .loadEn   (loadEn),
  .loadSel  (loadSel),
  .loadData (loadData),
  .opSel    (opSel),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/gf2_digit_alu_test.sv
module gf2_digit_alu_test;

  localparam int NW = 13;
  localparam int NI = 3;
  localparam logic [NW:0] FPOLY = 14'h201B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0, loadSel = 1'b0, start = 1'b0;
  logic [NW-1:0] loadData = '0;
  logic [1:0] opSel = 2'b00;

  logic          doneV   [NI];
  logic          busyV   [NI];
  logic [NW-1:0] resultV [NI];

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : gen_d
    gf2_digit_alu #(.FIELD_W(NW), .DIGIT_W(g + 1), .POLY(13'h001B)) uut (
      .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadSel(loadSel),
      .loadData(loadData), .opSel(opSel), .start(start),
      .busy(busyV[g]), .done(doneV[g]), .result(resultV[g])
    );
  end

  function automatic logic [NW-1:0] refMul(input logic [NW-1:0] x, input logic [NW-1:0] y);
    logic [2*NW-1:0] p = '0;
    for (int i = 0; i < NW; i++) if (y[i]) p = p ^ ((2*NW)'(x) << i);
    for (int i = 2*NW-1; i >= NW; i--) if (p[i]) p = p ^ ((2*NW)'(FPOLY) << (i - NW));
    return p[NW-1:0];
  endfunction

  function automatic int mulCycles(input int g);
    return (NW + g) / (g + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input logic sel, input logic [NW-1:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Runs one operation on all instances; optional stray start/load at cycle 2,
  // optional load of a in the start cycle.
  task automatic runOp(input logic [1:0] op, input logic [NW-1:0] expRes, input string tag,
                       input bit strayStart, input bit strayLoad, input logic [NW-1:0] strayVal,
                       input bit loadWithStart, input logic [NW-1:0] lval);
    int gotCyc [NI];
    int doneCnt [NI];
    logic [NW-1:0] gotRes [NI];
    for (int g = 0; g < NI; g++) begin gotCyc[g] = 0; doneCnt[g] = 0; gotRes[g] = '0; end
    @(negedge clk);
    start = 1'b1; opSel = op;
    if (loadWithStart) begin loadEn = 1'b1; loadSel = 1'b0; loadData = lval; end
    @(negedge clk);
    start = 1'b0; loadEn = 1'b0;
    for (int cyc = 1; cyc <= 16; cyc++) begin
      for (int g = 0; g < NI; g++) begin
        if (doneV[g]) begin
          doneCnt[g]++;
          if (gotCyc[g] == 0) begin gotCyc[g] = cyc; gotRes[g] = resultV[g]; end
        end
        if (op == 2'b10 && cyc == 1)
          check(busyV[g] == (mulCycles(g) > 1), {tag, " R4 busy"}, int'(busyV[g]), 1);
      end
      if (cyc == 2 && (strayStart || strayLoad)) begin
        if (strayStart) begin start = 1'b1; opSel = 2'b00; end
        if (strayLoad) begin loadEn = 1'b1; loadSel = 1'b0; loadData = strayVal; end
        @(negedge clk);
        start = 1'b0; loadEn = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    for (int g = 0; g < NI; g++) begin
      int expCyc = (op == 2'b10) ? mulCycles(g) : 1;
      check(gotCyc[g] == expCyc, (g == 0) ? {tag, " R5 cycles"} : {tag, " R4 cycles"},
            gotCyc[g], expCyc);
      check(gotRes[g] == expRes, (g == 0) ? {tag, " R5 value"} : {tag, " value"},
            int'(gotRes[g]), int'(expRes));
      check(doneCnt[g] == 1, {tag, " R6 single done"}, doneCnt[g], 1);
      check(resultV[g] == expRes, {tag, " R6 hold"}, int'(resultV[g]), int'(expRes));
    end
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    logic [NW-1:0] va, vb, vexp;
    logic [1:0] op;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    for (int g = 0; g < NI; g++) begin
      check(resultV[g] == '0, "R8 result", int'(resultV[g]), 0);
      check(doneV[g] == 1'b0 && busyV[g] == 1'b0, "R8 flags", int'({doneV[g], busyV[g]}), 0);
    end
    rst_n = 1'b1;
    // R8: registers cleared, add of zero operands gives zero
    runOp(2'b00, '0, "R8 add after reset", 0, 0, '0, 0, '0);

    // Directed corners
    loadReg(1'b0, 13'h1FFF); loadReg(1'b1, 13'h1FFF);
    runOp(2'b00, 13'h0000, "R2 all ones add", 0, 0, '0, 0, '0);
    runOp(2'b11, 13'h0000, "R2 alias add", 0, 0, '0, 0, '0);
    runOp(2'b10, refMul(13'h1FFF, 13'h1FFF), "R4 all ones mul", 0, 0, '0, 0, '0);
    loadReg(1'b0, 13'h0A5C); loadReg(1'b1, 13'h0001);
    runOp(2'b10, 13'h0A5C, "R4 mul by one", 0, 0, '0, 0, '0);
    loadReg(1'b0, 13'h1000);
    runOp(2'b01, refMul(13'h1000, 13'h1000), "R3 square top bit", 0, 0, '0, 0, '0);
    // R9: b consumed by the multiply above, a kept
    runOp(2'b00, 13'h1000, "R9 b cleared", 0, 0, '0, 0, '0);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      va = NW'($urandom); vb = NW'($urandom); op = 2'($urandom % 4);
      loadReg(1'b0, va); loadReg(1'b1, vb);
      if (op == 2'b10) vexp = refMul(va, vb);
      else if (op == 2'b01) vexp = refMul(va, va);
      else vexp = va ^ vb;
      runOp(op, vexp, (op == 2'b10) ? "R4 random" : (op == 2'b01) ? "R3 random" : "R2 random",
            0, 0, '0, 0, '0);
    end

    // R7: stray start during multiply
    va = 13'h1357; vb = 13'h0F0F;
    loadReg(1'b0, va); loadReg(1'b1, vb);
    runOp(2'b10, refMul(va, vb), "R7 stray start", 1, 0, '0, 0, '0);

    // R1: stray load of a during multiply is ignored
    loadReg(1'b1, vb);
    runOp(2'b10, refMul(va, vb), "R1 busy load", 0, 1, 13'h0123, 0, '0);
    runOp(2'b00, va, "R1 a kept R9", 0, 0, '0, 0, '0);

    // R1: load together with start is ignored
    loadReg(1'b1, 13'h00FF);
    runOp(2'b00, va ^ 13'h00FF, "R1 start plus load", 0, 0, '0, 1, 13'h1ABC);
    runOp(2'b00, va ^ 13'h00FF, "R1 a unchanged", 0, 0, '0, 0, '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule